// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing half of a byte-addressable serial memory. It watches the two-wire bus lines (SCL and SDA) with a system clock that runs much faster than the bus clock. It recognises START and STOP conditions and checks the incoming device address against the strap inputs. It then runs the write, current-address read, random read and sequential read sequences. SDA is driven only as an open-drain output enable: when the enable is high the line is pulled low.

Every data byte received in a write is handed to a separate page-write engine through a one-cycle strobe that carries the target address and the data byte. That engine commits the byte into the on-chip array through the array's write port, and it reports its self-timed programming cycle back through a busy input. Reads come straight from the inferred array through a registered read port, addressed by a single internal address counter. The array holds 2^ADDR_W bytes. The default is kept small, and ADDR_W = 14 gives a 16K x 8 array. Pages hold 2^PAGE_W bytes.

Top module: `i2c_mem_slave`

## Requirements
- R1: A STOP (SDA rising while SCL is high) returns the slave to idle and releases SDA. A START (SDA falling while SCL is high) seen at any point restarts device-address reception and discards any partly received byte. A data byte cut short by a STOP produces no write strobe.
- R2: The device address byte is sent MSB first. Its bits 7..4 must be 1010, its bits 3..1 must equal strap_i[2:0], and bit 0 selects read (1) or write (0). Only a matching address is acknowledged, by pulling SDA low during the ninth SCL clock. After a mismatch the slave acknowledges nothing until the next START.
- R3: While busy_i is high at the end of the device address byte, the slave does not acknowledge. Once busy_i is low, the same address is acknowledged again.
- R4: After a write device address, the slave takes two word-address bytes, high byte first, and acknowledges each one. Only the low ADDR_W bits of the 16-bit word address are used; the rest are don't-care.
- R5: Each data byte of a write is acknowledged and raises wr_stb_o for exactly one cycle, with wr_addr_o set to the current counter and wr_data_o set to the byte. The counter then increments only in its low PAGE_W bits, wrapping within the page, and keeps its upper bits.
- R6: The address counter holds the address of the last byte accessed plus one. A read device address sent right after a START returns the byte at that address.
- R7: A write device address, two word-address bytes, a repeated START and a read device address together return the byte at the loaded address. No write strobe is produced.
- R8: In a read, a master acknowledge (SDA low in the ninth clock) makes the slave send the byte at the next address. Read addressing wraps from the last byte of the array to address 0.
- R9: A master not-acknowledge ends the read: the slave stops driving SDA. The counter then points one past the last byte sent.
- R10: Bytes are transmitted MSB first, and the slave changes its SDA drive only while SCL is low.
- R11: After reset the slave is idle, SDA is released and no write strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| strap_i | input | 3 | Chip-select straps compared with address bits 3..1 |
| busy_i | input | 1 | Page-write engine programming cycle in progress |
| wr_stb_o | output | 1 | One-cycle strobe for a received write byte |
| wr_addr_o | output | ADDR_W | Array address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| mem_we_i | input | 1 | Array write enable from the page-write engine |
| mem_waddr_i | input | ADDR_W | Array write address |
| mem_wdata_i | input | 8 | Array write data |

## Verification
The assertions check four things on every cycle. SDA drive never changes while SCL is high. A write strobe lasts one cycle and always comes with an acknowledge. A STOP leaves the slave idle and silent on the next cycle. A device acknowledge never starts while busy was high. Address matching against every strap value, page wrap on writes, whole-array wrap on sequential reads, the counter value carried between transactions, repeated-START random reads and abort by START or STOP in mid-byte only show up across complete bus transactions, so the bench scenarios cover them.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   localparam int BYTE_W = 8;
   localparam int CNT_W  = 4;

   localparam logic [CNT_W-1:0] SLOT_ACK  = 4'd8;
   localparam logic [CNT_W-1:0] SLOT_POST = 4'd9;

   localparam logic [3:0] DEV_TAG = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WR,
      ST_RD
   } i2cm_state_e;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   localparam int LINES = 2;

   logic [LINES-1:0] raw;
   logic [LINES-1:0] lvl;
   logic [LINES-1:0] lvl_d;

   assign raw = {sda_i, scl_i};

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      if (STAGES > 1) begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
         end
      end else begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= raw[g];
         end
      end
      assign lvl[g] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= '1;
      else        lvl_d <= lvl;
   end

   assign scl_o      = lvl[0];
   assign sda_o      = lvl[1];
   assign scl_rise_o = lvl[0] & ~lvl_d[0];
   assign scl_fall_o = ~lvl[0] & lvl_d[0];
   assign start_o    = lvl[0] & lvl_d[0] & lvl_d[1] & ~lvl[1];
   assign stop_o     = lvl[0] & lvl_d[0] & ~lvl_d[1] & lvl[1];

endmodule

// File: rtl/i2cm_addr_ctr.sv
module i2cm_addr_ctr #(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_val_i,
   input  logic              inc_page_i,
   input  logic              inc_lin_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int ROW_W = ADDR_W - PAGE_W;

   logic [ADDR_W-1:0] ctr;
   logic [PAGE_W-1:0] col_nxt;

   assign col_nxt = ctr[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ctr <= '0;
      else if (load_i)     ctr <= load_val_i;
      else if (inc_page_i) ctr <= {ctr[ADDR_W-1:ADDR_W-ROW_W], col_nxt};
      else if (inc_lin_i)  ctr <= ctr + {{(ADDR_W-1){1'b0}}, 1'b1};
   end

   assign addr_o = ctr;

endmodule

// File: rtl/i2cm_mem.sv
module i2cm_mem #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) cells[waddr_i] <= wdata_i;
      rdata_o <= cells[raddr_i];
   end

endmodule

// File: rtl/i2cm_fsm.sv
module i2cm_fsm
   import i2cm_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              sda_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [2:0]        strap_i,
   input  logic              busy_i,
   input  logic [BYTE_W-1:0] rdata_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              sda_oe_o,
   output logic              wr_stb_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [BYTE_W-1:0] wr_data_o,
   output logic              ld_o,
   output logic [ADDR_W-1:0] ld_val_o,
   output logic              inc_page_o,
   output logic              inc_lin_o,
   output logic              dev_ack_o,
   output logic              idle_o
);

   i2cm_state_e       st;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh;
   logic              rw;
   logic              mack;
   logic              oe;
   logic              stb;
   logic [ADDR_W-1:0] wa;
   logic [BYTE_W-1:0] wd;
   logic              ld;
   logic              inc_p;
   logic              inc_l;

   logic byte_done;
   logic slot_end;
   logic dev_hit;
   logic quiet;

   assign quiet     = ~start_i & ~stop_i;
   assign byte_done = scl_fall_i && (cnt == SLOT_ACK);
   assign slot_end  = scl_fall_i && (cnt == SLOT_POST);
   assign dev_hit   = (sh[7:4] == DEV_TAG) && (sh[3:1] == strap_i);

   // high word-address bits exist only when the array needs them
   if (ADDR_W > BYTE_W) begin : g_wide
      logic [ADDR_W-BYTE_W-1:0] ahi;
      logic                     cap_hi;
      assign cap_hi = quiet && (st == ST_AHI) && byte_done;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      ahi <= '0;
         else if (cap_hi) ahi <= sh[ADDR_W-BYTE_W-1:0];
      end
      assign ld_val_o = {ahi, sh};
   end else begin : g_narrow
      assign ld_val_o = sh[ADDR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         sh    <= '0;
         rw    <= 1'b0;
         mack  <= 1'b1;
         oe    <= 1'b0;
         stb   <= 1'b0;
         wa    <= '0;
         wd    <= '0;
         ld    <= 1'b0;
         inc_p <= 1'b0;
         inc_l <= 1'b0;
      end else begin
         stb   <= 1'b0;
         ld    <= 1'b0;
         inc_p <= 1'b0;
         inc_l <= 1'b0;
         if (stop_i) begin
            st  <= ST_IDLE;
            cnt <= '0;
            oe  <= 1'b0;
         end else if (start_i) begin
            st  <= ST_DEV;
            cnt <= '0;
            oe  <= 1'b0;
         end else begin
            case (st)
               ST_IDLE: begin
               end
               ST_RD: begin
                  if (scl_rise_i) begin
                     if (cnt < SLOT_ACK) begin
                        cnt <= cnt + 4'd1;
                     end else if (cnt == SLOT_ACK) begin
                        mack <= sda_i;
                        cnt  <= SLOT_POST;
                     end
                  end else if (scl_fall_i) begin
                     if (cnt == SLOT_ACK) begin
                        oe    <= 1'b0;
                        inc_l <= 1'b1;
                     end else if (cnt == SLOT_POST) begin
                        cnt <= '0;
                        if (!mack) begin
                           sh <= rdata_i;
                           oe <= ~rdata_i[BYTE_W-1];
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else if (cnt != '0) begin
                        sh <= {sh[BYTE_W-2:0], 1'b0};
                        oe <= ~sh[BYTE_W-2];
                     end
                  end
               end
               default: begin
                  if (scl_rise_i && (cnt < SLOT_ACK)) begin
                     sh  <= {sh[BYTE_W-2:0], sda_i};
                     cnt <= cnt + 4'd1;
                  end else if (byte_done) begin
                     cnt <= SLOT_POST;
                     case (st)
                        ST_DEV: begin
                           if (dev_hit && !busy_i) begin
                              oe <= 1'b1;
                              rw <= sh[0];
                           end else begin
                              st  <= ST_IDLE;
                              cnt <= '0;
                           end
                        end
                        ST_AHI: oe <= 1'b1;
                        ST_ALO: begin
                           oe <= 1'b1;
                           ld <= 1'b1;
                        end
                        default: begin
                           oe    <= 1'b1;
                           stb   <= 1'b1;
                           wa    <= addr_i;
                           wd    <= sh;
                           inc_p <= 1'b1;
                        end
                     endcase
                  end else if (slot_end) begin
                     oe  <= 1'b0;
                     cnt <= '0;
                     case (st)
                        ST_DEV: begin
                           if (rw) begin
                              st <= ST_RD;
                              sh <= rdata_i;
                              oe <= ~rdata_i[BYTE_W-1];
                           end else begin
                              st <= ST_AHI;
                           end
                        end
                        ST_AHI:  st <= ST_ALO;
                        default: st <= ST_WR;
                     endcase
                  end
               end
            endcase
         end
      end
   end

   assign sda_oe_o   = oe;
   assign wr_stb_o   = stb;
   assign wr_addr_o  = wa;
   assign wr_data_o  = wd;
   assign ld_o       = ld;
   assign inc_page_o = inc_p;
   assign inc_lin_o  = inc_l;
   assign dev_ack_o  = (st == ST_DEV) && (cnt == SLOT_POST);
   assign idle_o     = (st == ST_IDLE);

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
   import i2cm_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int PAGE_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [2:0]        strap_i,
   input  logic              busy_i,
   output logic              wr_stb_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [BYTE_W-1:0] wr_data_o,
   input  logic              mem_we_i,
   input  logic [ADDR_W-1:0] mem_waddr_i,
   input  logic [BYTE_W-1:0] mem_wdata_i
);

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 2..16");
   end
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("PAGE_W must lie in 1..ADDR_W-1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_p;
   logic              stop_p;
   logic [BYTE_W-1:0] rdata;
   logic [ADDR_W-1:0] cur_addr;
   logic              ld;
   logic [ADDR_W-1:0] ld_val;
   logic              inc_page;
   logic              inc_lin;
   logic              dev_ack;
   logic              fsm_idle;

   i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_o      (scl_s),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_p),
      .stop_o     (stop_p)
   );

   i2cm_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall & ~scl_s),
      .sda_i      (sda_s),
      .start_i    (start_p),
      .stop_i     (stop_p),
      .strap_i    (strap_i),
      .busy_i     (busy_i),
      .rdata_i    (rdata),
      .addr_i     (cur_addr),
      .sda_oe_o   (sda_oe_o),
      .wr_stb_o   (wr_stb_o),
      .wr_addr_o  (wr_addr_o),
      .wr_data_o  (wr_data_o),
      .ld_o       (ld),
      .ld_val_o   (ld_val),
      .inc_page_o (inc_page),
      .inc_lin_o  (inc_lin),
      .dev_ack_o  (dev_ack),
      .idle_o     (fsm_idle)
   );

   i2cm_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ld),
      .load_val_i (ld_val),
      .inc_page_i (inc_page),
      .inc_lin_i  (inc_lin),
      .addr_o     (cur_addr)
   );

   i2cm_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
      .clk     (clk),
      .we_i    (mem_we_i),
      .waddr_i (mem_waddr_i),
      .wdata_i (mem_wdata_i),
      .raddr_i (cur_addr),
      .rdata_o (rdata)
   );

endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic busy_i,
   input logic sda_oe,
   input logic wr_stb,
   input logic stop_p,
   input logic idle,
   input logic dev_ack
);

   // R10
   oe_steady_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i)) |-> $stable(sda_oe));

   // R5
   stb_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R5
   stb_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> sda_oe);

   // R1
   stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> (!sda_oe && idle));

   // R3
   busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_ack) |-> !$past(busy_i));

endmodule

bind i2c_mem_slave i2cm_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_i   (scl_i),
   .busy_i  (busy_i),
   .sda_oe  (sda_oe_o),
   .wr_stb  (wr_stb_o),
   .stop_p  (stop_p),
   .idle    (fsm_idle),
   .dev_ack (dev_ack)
);

// File: tb/i2c_mem_slave_test.sv
`timescale 1ns/1ps
module i2c_mem_slave_test;

   localparam int AW = 8;
   localparam int PW = 3;
   localparam int Q  = 5;
   localparam int N  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scl_m = 1'b1;
   logic          sda_m = 1'b1;
   logic          sda_line;
   logic          sda_oe;
   logic [2:0]    strap = 3'b101;
   logic          busy = 1'b0;
   logic          wr_stb;
   logic [AW-1:0] wr_addr;
   logic [7:0]    wr_data;
   logic          pre_we = 1'b0;
   logic [AW-1:0] pre_a = '0;
   logic [7:0]    pre_d = '0;
   logic          m_we;
   logic [AW-1:0] m_wa;
   logic [7:0]    m_wd;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;
   int n_stb = 0;
   logic [AW-1:0] lg_a [64];
   logic [7:0]    lg_d [64];
   logic [7:0]    exp_mem [N];

   always #2 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;
   assign m_we  = pre_we | wr_stb;
   assign m_wa  = pre_we ? pre_a : wr_addr;
   assign m_wd  = pre_we ? pre_d : wr_data;

   i2c_mem_slave #(.ADDR_W(AW), .PAGE_W(PW), .SYNC_STAGES(2)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_line),
      .sda_oe_o    (sda_oe),
      .strap_i     (strap),
      .busy_i      (busy),
      .wr_stb_o    (wr_stb),
      .wr_addr_o   (wr_addr),
      .wr_data_o   (wr_data),
      .mem_we_i    (m_we),
      .mem_waddr_i (m_wa),
      .mem_wdata_i (m_wd)
   );

   always @(posedge clk) begin
      if (rst_n && wr_stb) begin
         if (n_stb < 64) begin
            lg_a[n_stb] = wr_addr;
            lg_d[n_stb] = wr_data;
         end
         n_stb = n_stb + 1;
      end
   end

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   task automatic w();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; w();
      scl_m = 1'b1; w();
      sda_m = 1'b0; w();
      scl_m = 1'b0; w();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; w();
      scl_m = 1'b1; w();
      sda_m = 1'b1; w(); w();
   endtask

   task automatic put_bit(input bit b);
      sda_m = b; w();
      scl_m = 1'b1; w(); w();
      scl_m = 1'b0; w();
   endtask

   task automatic get_bit(output bit b);
      sda_m = 1'b1; w();
      scl_m = 1'b1; w();
      b = sda_line; w();
      scl_m = 1'b0; w();
   endtask

   task automatic put_byte(input logic [7:0] d, output bit acked);
      bit b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      acked = !b;
   endtask

   task automatic get_byte(input bit give_ack, output logic [7:0] d);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(!give_ack);
   endtask

   // write device address, high byte, low byte; each must be acknowledged
   task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
      bit ak;
      bus_start();
      put_byte({4'b1010, strap, 1'b0}, ak);
      chk(ak, {req, " device write ack"}, ak, 1);
      put_byte(hi, ak);
      chk(ak, "R4 high word address ack", ak, 1);
      put_byte(lo, ak);
      chk(ak, "R4 low word address ack", ak, 1);
   endtask

   task automatic cur_read(input int exp_a, input string req);
      bit ak;
      logic [7:0] d;
      bus_start();
      put_byte({4'b1010, strap, 1'b1}, ak);
      chk(ak, {req, " read address ack"}, ak, 1);
      get_byte(1'b0, d);
      chk(d == exp_mem[exp_a & (N-1)], {req, " read data"}, d, exp_mem[exp_a & (N-1)]);
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=expired expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      bit ak;
      bit b;
      logic [7:0] d;
      int n0;
      int a;

      // preload the array as the page-write engine would
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         pre_we = 1'b1;
         pre_a  = AW'(i);
         pre_d  = pat(i);
         exp_mem[i] = pat(i);
      end
      @(negedge clk);
      pre_we = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R11 reset state
      chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
      chk(wr_stb == 1'b0, "R11 no strobe", wr_stb, 0);

      // R2 every 7-bit address against the fixed strap
      for (int dv = 0; dv < 128; dv++) begin
         bus_start();
         put_byte({7'(dv), 1'b0}, ak);
         chk(ak == (dv == {4'b1010, 3'b101}), "R2 address sweep", ak, dv == {4'b1010, 3'b101});
         bus_stop();
      end

      // R2 every strap value against every chip-select code
      for (int s = 0; s < 8; s++) begin
         strap = 3'(s);
         for (int c = 0; c < 8; c++) begin
            bus_start();
            put_byte({4'b1010, 3'(c), 1'b0}, ak);
            chk(ak == (c == s), "R2 strap sweep", ak, c == s);
            bus_stop();
         end
      end
      strap = 3'b101;

      // R2 nothing acknowledged after a mismatch until START
      bus_start();
      put_byte({4'b1010, 3'b011, 1'b0}, ak);
      chk(!ak, "R2 mismatch nack", ak, 0);
      put_byte(8'h55, ak);
      chk(!ak, "R2 ignored after mismatch", ak, 0);
      bus_stop();

      // R4 R5 byte write, high word-address byte is don't-care at this size
      n0 = n_stb;
      set_addr(8'hA7, 8'h3A, "R4");
      put_byte(8'h5C, ak);
      chk(ak, "R5 data ack", ak, 1);
      bus_stop();
      chk(n_stb == n0 + 1, "R5 strobe count", n_stb - n0, 1);
      chk(lg_a[n0] == 8'h3A, "R5 strobe address", lg_a[n0], 8'h3A);
      chk(lg_d[n0] == 8'h5C, "R5 strobe data", lg_d[n0], 8'h5C);
      exp_mem[8'h3A] = 8'h5C;

      // R6 counter = last accessed + 1
      cur_read(8'h3B, "R6");

      // R5 page write wrapping inside an 8-byte page
      n0 = n_stb;
      set_addr(8'h00, 8'h45, "R5");
      for (int i = 0; i < 6; i++) begin
         put_byte(8'hC0 + 8'(i), ak);
         chk(ak, "R5 page data ack", ak, 1);
      end
      bus_stop();
      chk(n_stb == n0 + 6, "R5 page strobe count", n_stb - n0, 6);
      for (int i = 0; i < 6; i++) begin
         a = 8'h40 + ((5 + i) % 8);
         chk(lg_a[n0 + i] == AW'(a), "R5 page wrap address", lg_a[n0 + i], a);
         chk(lg_d[n0 + i] == 8'hC0 + 8'(i), "R5 page data", lg_d[n0 + i], 8'hC0 + i);
         exp_mem[a] = 8'hC0 + 8'(i);
      end
      cur_read(8'h43, "R6 after page wrap");

      // R7 random read via dummy write and repeated START
      n0 = n_stb;
      set_addr(8'h00, 8'h90, "R7");
      cur_read(8'h90, "R7");
      chk(n_stb == n0, "R7 no strobe", n_stb - n0, 0);

      // R8 R10 sequential read across the end of the array
      set_addr(8'h00, 8'hFC, "R8");
      bus_start();
      put_byte({4'b1010, strap, 1'b1}, ak);
      chk(ak, "R8 read address ack", ak, 1);
      for (int i = 0; i < 260; i++) begin
         a = (8'hFC + i) & (N - 1);
         get_byte(i < 259, d);
         chk(d == exp_mem[a], "R8 R10 sequential data", d, exp_mem[a]);
      end
      // R9 slave silent after the NACK
      get_bit(b);
      chk(b == 1'b1, "R9 released after nack", b, 1);
      bus_stop();
      cur_read((8'hFC + 260) & (N - 1), "R9 counter past last byte");

      // R3 busy blocks the device acknowledge
      busy = 1'b1;
      bus_start();
      put_byte({4'b1010, strap, 1'b0}, ak);
      chk(!ak, "R3 busy write nack", ak, 0);
      bus_stop();
      bus_start();
      put_byte({4'b1010, strap, 1'b1}, ak);
      chk(!ak, "R3 busy read nack", ak, 0);
      bus_stop();
      busy = 1'b0;
      cur_read(1, "R3 ack after busy");

      // R1 START in mid-byte restarts address reception
      bus_start();
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
      set_addr(8'h00, 8'h10, "R1 after restart");
      cur_read(8'h10, "R1 restart");

      // R1 STOP in mid data byte writes nothing
      n0 = n_stb;
      set_addr(8'h00, 8'h20, "R1");
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
      bus_stop();
      chk(n_stb == n0, "R1 no strobe after stop", n_stb - n0, 0);
      chk(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);
      cur_read(8'h20, "R1 counter kept");

      done = 1'b1;
      summary();
      $finish;
   end

endmodule